// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. A CPU-side write strobe places a character in a one-entry holding buffer. When the transmitter is idle and allowed to start, that buffer is copied into a frame shift register, and the frame is sent one bit at a time. The frame is a start bit, 7, 8 or 9 character bits, an optional parity bit and one or two stop bits. Each bit lasts 16 pulses of an external tick that runs at sixteen times the bit rate. That tick normally comes from a divider giving clk / (16 x (n+1)) with n from 0 to 255.

A frame can start only when transmit is enabled and the holding buffer holds data. When flow gating is selected, a low clear-to-send input is also needed. That input is looked at only at frame start. The character format is captured when the frame starts. Options select the bit order, invert only the character and parity bits, or invert the whole line including idle. The interrupt pulse is raised either when the buffer is handed to the shift register or when the last stop bit has finished.

The asynchronous active-low reset reaches the logic through a two-stage synchronizer, so its release takes effect on the second clock edge after `rst_n` rises.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, busy=0, irq=0, buf_empty=1, and tx_out is at the idle mark level (1 when pin_invert=0, 0 when pin_invert=1).
- R2: A cycle with wr_en=1 stores wr_data in the holding buffer and clears buf_empty from the next cycle. A write while the buffer is full replaces its contents. buf_empty rises in the cycle after the buffer is taken by a frame, unless a write arrives in that same cycle.
- R3: A frame is taken in a clock cycle only if busy=0, the buffer is full, tx_enable=1, and either cts_gate_en=0 or cts_n=0. busy rises and the start bit appears on the next cycle. char_len, parity_mode, two_stop, msb_first and data_invert are captured in that cycle.
- R4: The frame is one start bit (0), then the character bits, then an optional parity bit, then stop bits (1). Character length: char_len 00 = 7 bits, 01 = 8 bits, 10 or 11 = 9 bits. Stop bits: two_stop=0 gives one, two_stop=1 gives two. Each bit is held for 16 tick_16x pulses, counted from the cycle after the frame is taken.
- R5: parity_mode 01 = even and 10 = odd, with a parity bit after the character. 00 and 11 send no parity bit. The parity covers only the configured character bits of wr_data; higher bits are ignored, as they are for the character itself.
- R6: msb_first=0 sends character bit 0 first. msb_first=1 sends the top configured bit (bit 6, 7 or 8) first.
- R7: data_invert=1 inverts the character bits and the parity bit on the line. The start and stop bits are not inverted.
- R8: pin_invert=1 inverts tx_out at all times, idle included. It takes effect at once and is not captured per frame.
- R9: irq is a one-cycle pulse. With irq_on_done=0 it appears in the cycle busy rises. With irq_on_done=1 it appears in the cycle busy falls, after the last stop bit's 16th tick.
- R10: Once a frame has started, changing cts_n, cts_gate_en or tx_enable does not shorten or alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 9 | Character to send |
| tx_enable | input | 1 | Allows new frames to start |
| cts_gate_en | input | 1 | Selects clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| char_len | input | 2 | Character length code |
| parity_mode | input | 2 | Parity mode code |
| two_stop | input | 1 | Two stop bits when 1 |
| msb_first | input | 1 | Most significant bit first when 1 |
| data_invert | input | 1 | Invert character and parity bits |
| pin_invert | input | 1 | Invert the whole output line |
| irq_on_done | input | 1 | irq on frame end (1) or buffer hand-off (0) |
| tx_out | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer can take a write |
| busy | output | 1 | A frame is being sent |
| irq | output | 1 | Interrupt pulse |

## Verification
A wrong bit in the frame shift register shows on tx_out within one bit time, that is 16 ticks, of the bit falling due. A wrong bit-counter value shows as a frame that is too short or too long: busy and the done-mode irq pulse land a whole bit time away from the expected edge. A stuck holding-buffer flag shows on buf_empty in the next cycle. A gating error shows as busy rising in a cycle where the reference model keeps the line idle. The reference model is compared on tx_out, buf_empty, busy and irq every cycle, so any of these faults is reported in the cycle it reaches a port.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [1:0] char_len;
    par_mode_e  par_mode;
    logic       two_stop;
    logic       msb_first;
    logic       data_inv;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_nx;
  logic [DATA_W-1:0] data_nx;

  always_comb begin
    full_nx = full;
    data_nx = data;
    if (take)  full_nx = 1'b0;
    if (wr_en) begin
      full_nx = 1'b1;
      data_nx = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_nx;
      data <= data_nx;
    end
  end

  // R2: a write always leaves the buffer full with the written word
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (full && data == $past(wr_data)));

  // R2: a hand-off without a concurrent write frees the buffer
  a_r2_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> !full);

endmodule

// File: rtl/uart_tx_pacer.sv
module uart_tx_pacer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic bit_end
);

  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             cnt_en;

  assign cnt_en  = restart || (run && tick);
  assign bit_end = run && tick && (cnt == LAST);

  always_comb begin
    cnt_nx = cnt;
    if (restart)      cnt_nx = '0;
    else if (bit_end) cnt_nx = '0;
    else if (run && tick) cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nx;
  end

  // R4: the count does not move between ticks
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  frame_cfg_t        cfg,
  input  logic [DATA_W-1:0] din,
  input  logic              bit_end,
  output logic              busy,
  output logic              line,
  output logic              done
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int LEFT_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh, sh_nx, frm;
  logic [LEFT_W-1:0]  left, left_nx;
  logic               busy_nx;
  logic [DATA_W-1:0]  ord;
  logic               par_en, par_bit;
  int                 nchr, total;

  // Build the complete frame from the buffered word and the captured format
  always_comb begin
    nchr    = (cfg.char_len == 2'b00) ? DATA_W - 2 :
              (cfg.char_len == 2'b01) ? DATA_W - 1 : DATA_W;
    par_en  = (cfg.par_mode == PAR_EVEN) || (cfg.par_mode == PAR_ODD);
    par_bit = (cfg.par_mode == PAR_ODD);
    ord     = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nchr) par_bit = par_bit ^ din[i];
      for (int j = 0; j < DATA_W; j++) begin
        if (cfg.msb_first ? (j == nchr - 1 - i) : (j == i)) ord[i] = din[j];
      end
    end
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nchr) frm[1+i] = ord[i] ^ cfg.data_inv;
    end
    for (int k = DATA_W - 2; k <= DATA_W; k++) begin
      if (par_en && k == nchr) frm[1+k] = par_bit ^ cfg.data_inv;
    end
    total = 1 + nchr + (par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1);
  end

  assign done = busy && bit_end && (left == '0);
  assign line = busy ? sh[0] : 1'b1;

  always_comb begin
    sh_nx   = sh;
    left_nx = left;
    busy_nx = busy;
    if (load) begin
      sh_nx   = frm;
      left_nx = LEFT_W'(total - 1);
      busy_nx = 1'b1;
    end else if (done) begin
      busy_nx = 1'b0;
    end else if (busy && bit_end) begin
      sh_nx   = {1'b1, sh[FRAME_W-1:1]};
      left_nx = left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else begin
      sh   <= sh_nx;
      left <= left_nx;
      busy <= busy_nx;
    end
  end

  // R4: every frame opens with a low start bit
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (line == 1'b0));

  // R7: the bit sent just before returning to idle is a true stop bit
  a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(line));

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              cts_gate_en,
  input  logic              cts_n,
  input  logic [1:0]        char_len,
  input  logic [1:0]        parity_mode,
  input  logic              two_stop,
  input  logic              msb_first,
  input  logic              data_invert,
  input  logic              pin_invert,
  input  logic              irq_on_done,
  output logic              tx_out,
  output logic              buf_empty,
  output logic              busy,
  output logic              irq
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              hb_full, load, bit_end, done, line, irq_nx;
  logic [DATA_W-1:0] hb_data;
  frame_cfg_t        cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cfg  = '{char_len:  char_len,
                  par_mode:  par_mode_e'(parity_mode),
                  two_stop:  two_stop,
                  msb_first: msb_first,
                  data_inv:  data_invert};
  assign load = !busy && hb_full && tx_enable && (!cts_gate_en || !cts_n);

  uart_tx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load), .full(hb_full), .data(hb_data)
  );

  uart_tx_pacer #(.TICKS(TICKS)) u_pace (
    .clk(clk), .rst_n(rst_sync_n), .restart(load), .run(busy),
    .tick(tick_16x), .bit_end(bit_end)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .cfg(cfg), .din(hb_data),
    .bit_end(bit_end), .busy(busy), .line(line), .done(done)
  );

  assign irq_nx = irq_on_done ? done : load;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq <= 1'b0;
    else             irq <= irq_nx;
  end

  assign tx_out    = line ^ pin_invert;
  assign buf_empty = !hb_full;

  // R3: a frame only starts when enabled and clear to send
  a_r3_start_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> ($past(tx_enable) && (!$past(cts_gate_en) || !$past(cts_n))));

  // R9: interrupt is a single-cycle pulse
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |=> !irq);

  // R9: done mode pulses as the frame ends, empty mode as it begins
  a_r9_irq_done_edge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && $past(irq_on_done)) |-> $fell(busy));
  a_r9_irq_empty_edge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && !$past(irq_on_done)) |-> $rose(busy));

  // R8: idle line sits at mark, flipped by the pin polarity option
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (tx_out == !pin_invert));

endmodule

// File: tb/tb_uart_tx_core.sv
`timescale 1ns/1ps
module tb_uart_tx_core;

  logic       clk, rst_n, tick_16x, wr_en, tx_enable, cts_gate_en, cts_n;
  logic [8:0] wr_data;
  logic [1:0] char_len, parity_mode;
  logic       two_stop, msb_first, data_invert, pin_invert, irq_on_done;
  logic       tx_out, buf_empty, busy, irq;

  int    n_chk = 0, n_fail = 0;
  int    tick_per = 1, tcnt = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  uart_tx_core dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .wr_en(wr_en),
    .wr_data(wr_data), .tx_enable(tx_enable), .cts_gate_en(cts_gate_en),
    .cts_n(cts_n), .char_len(char_len), .parity_mode(parity_mode),
    .two_stop(two_stop), .msb_first(msb_first), .data_invert(data_invert),
    .pin_invert(pin_invert), .irq_on_done(irq_on_done), .tx_out(tx_out),
    .buf_empty(buf_empty), .busy(busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Tick generator: one pulse every tick_per cycles
  always @(negedge clk) begin
    if (tcnt >= tick_per - 1) begin tcnt <= 0; tick_16x <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick_16x <= 1'b0; end
  end

  // Behavioural reference: queue of line levels still to send
  bit   m_q[$];
  bit   m_full, m_busy, m_irq;
  logic [8:0] m_data;
  int   m_sub;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_full = 0; m_busy = 0; m_irq = 0; m_sub = 0; m_data = 0;
    end else begin
      bit go, fin, p;
      int n;
      go  = !m_busy && m_full && tx_enable && (!cts_gate_en || !cts_n);
      fin = m_busy && tick_16x && m_sub == 15 && m_q.size() == 1;
      m_irq = irq_on_done ? fin : go;
      if (m_busy && tick_16x) begin
        if (m_sub == 15) begin
          m_sub = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 0;
        end else m_sub++;
      end
      if (go) begin
        n = (char_len == 2'd0) ? 7 : (char_len == 2'd1) ? 8 : 9;
        p = (parity_mode == 2'd2);
        m_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
          p = p ^ m_data[i];
          m_q.push_back((msb_first ? m_data[n-1-i] : m_data[i]) ^ data_invert);
        end
        if (parity_mode == 2'd1 || parity_mode == 2'd2) m_q.push_back(p ^ data_invert);
        m_q.push_back(1'b1);
        if (two_stop) m_q.push_back(1'b1);
        m_busy = 1; m_sub = 0; m_full = 0;
      end
      if (wr_en) begin m_full = 1; m_data = wr_data; end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit line;
      line = m_busy ? m_q[0] : 1'b1;
      chk(cur_req, "tx_out",    32'(tx_out),    32'(line ^ pin_invert));
      chk(cur_req, "busy",      32'(busy),      32'(m_busy));
      chk(cur_req, "buf_empty", 32'(buf_empty), 32'(!m_full));
      chk(cur_req, "irq",       32'(irq),       32'(m_irq));
    end
  end

  int irq_seen = 0;
  always @(negedge clk) if (irq === 1'b1) irq_seen++;

  task automatic cfg(input logic [1:0] cl, input logic [1:0] pm, input logic ts,
                     input logic mf, input logic di);
    @(negedge clk);
    char_len = cl; parity_mode = pm; two_stop = ts; msb_first = mf; data_invert = di;
  endtask

  task automatic put(input logic [8:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (!m_busy && !m_full) break;
    end
  endtask

  task automatic send(input logic [8:0] d);
    put(d); wait_idle(); repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_16x = 1'b0; wr_en = 1'b0; wr_data = '0; tx_enable = 1'b0;
    cts_gate_en = 1'b0; cts_n = 1'b1; char_len = 2'd1; parity_mode = 2'd0;
    two_stop = 1'b0; msb_first = 1'b0; data_invert = 1'b0; pin_invert = 1'b0;
    irq_on_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, both polarities
    chk("R1", "tx_out idle", 32'(tx_out), 32'd1);
    chk("R1", "buf_empty", 32'(buf_empty), 32'd1);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);
    pin_invert = 1'b1;
    @(negedge clk);
    chk("R1", "tx_out inverted idle", 32'(tx_out), 32'd0);
    pin_invert = 1'b0;
    cmp_on = 1;

    cur_req = "R4"; tx_enable = 1'b1;
    send(9'h0A5);
    cfg(2'd0, 2'd0, 1'b1, 1'b0, 1'b0); send(9'h13C);
    tick_per = 3;
    cfg(2'd2, 2'd0, 1'b0, 1'b0, 1'b0); send(9'h1C3);
    tick_per = 1;

    cur_req = "R5";
    cfg(2'd0, 2'd1, 1'b0, 1'b0, 1'b0); send(9'h1FF);
    cfg(2'd0, 2'd2, 1'b0, 1'b0, 1'b0); send(9'h181);
    cfg(2'd2, 2'd2, 1'b1, 1'b0, 1'b0); send(9'h155);
    cfg(2'd1, 2'd3, 1'b0, 1'b0, 1'b0); send(9'h0F0);

    cur_req = "R6";
    cfg(2'd2, 2'd1, 1'b0, 1'b1, 1'b0); send(9'h101);
    cfg(2'd0, 2'd0, 1'b0, 1'b1, 1'b0); send(9'h046);

    cur_req = "R7";
    cfg(2'd1, 2'd1, 1'b1, 1'b0, 1'b1); send(9'h03A);
    cfg(2'd2, 2'd2, 1'b0, 1'b1, 1'b1); send(9'h1E2);

    cur_req = "R8";
    cfg(2'd1, 2'd2, 1'b0, 1'b0, 1'b0);
    put(9'h0C9);
    repeat (40) @(negedge clk);
    pin_invert = 1'b1;
    repeat (60) @(negedge clk);
    pin_invert = 1'b0;
    wait_idle();
    pin_invert = 1'b1; repeat (3) @(negedge clk);
    chk("R8", "idle with pin_invert", 32'(tx_out), 32'd0);
    pin_invert = 1'b0;

    cur_req = "R9";
    irq_seen = 0;
    cfg(2'd1, 2'd0, 1'b0, 1'b0, 1'b0); send(9'h011);
    chk("R9", "irq pulses per frame (empty mode)", 32'(irq_seen), 32'd1);
    irq_on_done = 1'b1; irq_seen = 0;
    send(9'h022);
    chk("R9", "irq pulses per frame (done mode)", 32'(irq_seen), 32'd1);
    // back-to-back: refill while busy
    put(9'h033);
    repeat (20) @(negedge clk);
    put(9'h044);
    chk("R2", "buffer refilled while busy", 32'(buf_empty), 32'd0);
    wait_idle(); repeat (3) @(negedge clk);
    irq_on_done = 1'b0;

    cur_req = "R2";
    tx_enable = 1'b0;
    put(9'h055); put(9'h0AA);
    repeat (5) @(negedge clk);
    chk("R2", "held while disabled", 32'(busy), 32'd0);
    tx_enable = 1'b1;
    wait_idle(); repeat (3) @(negedge clk);

    cur_req = "R3";
    cts_gate_en = 1'b1; cts_n = 1'b1;
    put(9'h0E7);
    repeat (50) @(negedge clk);
    chk("R3", "blocked by cts_n", 32'(busy), 32'd0);
    cts_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3", "started after cts_n low", 32'(busy), 32'd1);

    cur_req = "R10";
    cts_n = 1'b1; tx_enable = 1'b0;
    repeat (30) @(negedge clk);
    cts_gate_en = 1'b0;
    wait_idle(); repeat (3) @(negedge clk);
    chk("R10", "frame completed", 32'(busy), 32'd0);
    tx_enable = 1'b1; cts_n = 1'b0;

    repeat (5) @(negedge clk);
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule